// File: doc/BRIEF.md
# Interrupt redirection message dispatcher

The dispatcher sits between a set of device interrupt lines and the processor-local interrupt controllers. It keeps one redirection entry per input line. Each entry holds a mask bit, an 8-bit vector, a 3-bit delivery mode, a destination-mode bit and an 8-bit destination. When a line shows a rising edge, the block looks up that line's entry and turns it into interrupt messages on a valid/ready output channel.

In physical destination mode one message goes to the controller whose ID equals the destination field. In logical destination mode the destination field is a bitmask. The block sends one message for each set bit, with target ID equal to the bit position, lowest bit first. Masked entries produce nothing. Entries that carry one of the two reserved delivery modes produce no message; instead they set a sticky error flag and record the offending line. Software loads entries through a write port that takes 32-bit halves.

Top module: `irq_redirect_dispatch`

## Requirements
- R1: After reset, msg_valid, busy and err_flag are 0, and every entry is masked, so a rising edge on any line produces no message.
- R2: A write with cfg_wr_hi=0 loads the low half of the entry selected by cfg_wr_idx: vector from data bits 7:0, delivery mode from 10:8, destination mode from bit 11, mask from bit 16. A write with cfg_wr_hi=1 loads the destination from data bits 31:24. The other bits of the data word have no effect.
- R3: A signalled line whose entry has mask=1 produces no message and does not change err_flag.
- R4: With destination mode 0 (physical), exactly one message is sent. Its msg_target equals the destination field, and msg_dest, msg_vector, msg_mode and msg_dest_mode carry the entry's fields.
- R5: With destination mode 1 (logical), one message is sent for each set bit of the destination, with msg_target equal to that bit position, in ascending order. A destination of 0 sends nothing.
- R6: An unmasked entry with delivery mode 3 or 6 sends no message, sets err_flag (which stays set until reset), and sets err_line to that line number.
- R7: Lines are edge-detected. A line held high counts as one event. Pending events are serviced one at a time, lowest line number first.
- R8: busy is high from the first message of an event until the last message of that event is accepted (msg_valid and msg_ready both high). Lines that become pending meanwhile are held until then.
- R9: While msg_valid is high and msg_ready is low, msg_valid and all message fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Interrupt input lines, rising-edge sensitive |
| cfg_wr_en | input | 1 | Entry write strobe |
| cfg_wr_idx | input | IDX_W | Entry index to write |
| cfg_wr_hi | input | 1 | 0 selects the low half, 1 selects the high half |
| cfg_wr_data | input | 32 | Write data |
| msg_valid | output | 1 | Message valid |
| msg_ready | input | 1 | Message accepted by the receiver |
| msg_target | output | 8 | Controller ID addressed by this message |
| msg_dest | output | 8 | Destination field copied from the entry |
| msg_vector | output | 8 | Vector copied from the entry |
| msg_mode | output | 3 | Delivery mode copied from the entry |
| msg_dest_mode | output | 1 | Destination mode copied from the entry |
| busy | output | 1 | An event's messages are still being sent |
| err_flag | output | 1 | Sticky reserved-delivery-mode error |
| err_line | output | IDX_W | Line number of the latest reserved-mode event |

## Verification
If the remaining-bits register of a logical fan-out is corrupted, the message stream shows it at once: a target is skipped, repeated or out of order, or a stray message follows within one accepted handshake. If pending state is lost or duplicated, it shows as a missing or extra message group, or as line groups out of ascending order, within the few cycles it takes to drain. A fault in the error path shows on err_flag or err_line in the cycle after the event is taken. The bench compares the complete accepted message stream, and the error outputs, against a model built from its own shadow copy of the table, using both random and stalled ready patterns.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   localparam int CFG_W      = 32;
   localparam int VEC_W      = 8;
   localparam int DEST_W     = 8;
   localparam int MODE_W     = 3;
   localparam int ID_W       = $clog2(DEST_W);
   localparam int LO_VEC_LSB = 0;
   localparam int LO_MODE_LSB = 8;
   localparam int LO_DM_BIT  = 11;
   localparam int LO_MASK_BIT = 16;
   localparam int HI_DEST_LSB = 24;

   localparam logic [MODE_W-1:0] MODE_RSV_A = 3'd3;
   localparam logic [MODE_W-1:0] MODE_RSV_B = 3'd6;

   typedef struct packed {
      logic              mask;
      logic              dm;
      logic [MODE_W-1:0] mode;
      logic [VEC_W-1:0]  vec;
      logic [DEST_W-1:0] dest;
   } redir_entry_t;

   function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
      return (m == MODE_RSV_A) || (m == MODE_RSV_B);
   endfunction

   function automatic logic [ID_W-1:0] lowest_set(input logic [DEST_W-1:0] v);
      logic [ID_W-1:0] r;
      r = '0;
      for (int i = DEST_W - 1; i >= 0; i--)
         if (v[i]) r = ID_W'(i);
      return r;
   endfunction
endpackage

// File: rtl/irqd_table.sv
module irqd_table
   import irqd_pkg::*;
#(
   parameter int NUM_LINES = 24,
   localparam int IDX_W = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_hi,
   input  logic [CFG_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output redir_entry_t     rd_entry
);
   redir_entry_t entries [NUM_LINES];

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{wr_data[23:17], wr_data[15:12]};

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            entries[g]      <= '0;
            entries[g].mask <= 1'b1;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            if (wr_hi) begin
               entries[g].dest <= wr_data[HI_DEST_LSB +: DEST_W];
            end else begin
               entries[g].vec  <= wr_data[LO_VEC_LSB +: VEC_W];
               entries[g].mode <= wr_data[LO_MODE_LSB +: MODE_W];
               entries[g].dm   <= wr_data[LO_DM_BIT];
               entries[g].mask <= wr_data[LO_MASK_BIT];
            end
         end
      end
   end

   always_comb begin
      rd_entry = entries[0];
      for (int i = 0; i < NUM_LINES; i++)
         if (rd_idx == IDX_W'(i)) rd_entry = entries[i];
   end
endmodule

// File: rtl/irqd_edge_latch.sv
module irqd_edge_latch #(
   parameter int NUM_LINES = 24,
   localparam int IDX_W = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines,
   input  logic                 take,
   output logic                 sel_valid,
   output logic [IDX_W-1:0]     sel_idx
);
   logic [NUM_LINES-1:0] prev_q;
   logic [NUM_LINES-1:0] pend_q;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q[g] <= 1'b0;
            pend_q[g] <= 1'b0;
         end else begin
            prev_q[g] <= lines[g];
            pend_q[g] <= (pend_q[g] & ~(take && sel_idx == IDX_W'(g)))
                         | (lines[g] & ~prev_q[g]);
         end
      end

      assert_edge_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (lines[g] && !prev_q[g]) |=> pend_q[g]);
   end

   always_comb begin
      sel_valid = |pend_q;
      sel_idx   = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--)
         if (pend_q[i]) sel_idx = IDX_W'(i);
   end
endmodule

// File: rtl/irqd_fanout.sv
module irqd_fanout
   import irqd_pkg::*;
#(
   parameter int NUM_LINES = 24,
   localparam int IDX_W = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [IDX_W-1:0]  take_idx,
   input  redir_entry_t      take_entry,
   output logic              msg_valid,
   input  logic              msg_ready,
   output logic [DEST_W-1:0] msg_target,
   output logic [DEST_W-1:0] msg_dest,
   output logic [VEC_W-1:0]  msg_vector,
   output logic [MODE_W-1:0] msg_mode,
   output logic              msg_dest_mode,
   output logic              busy,
   output logic              err_flag,
   output logic [IDX_W-1:0]  err_line
);
   typedef enum logic {ST_IDLE, ST_SEND} state_t;
   state_t            state_q;
   logic [DEST_W-1:0] remain_q;
   logic [ID_W-1:0]   rem_low, ent_low;

   always_comb begin
      rem_low = lowest_set(remain_q);
      ent_low = lowest_set(take_entry.dest);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         remain_q      <= '0;
         msg_valid     <= 1'b0;
         msg_target    <= '0;
         msg_dest      <= '0;
         msg_vector    <= '0;
         msg_mode      <= '0;
         msg_dest_mode <= 1'b0;
         err_flag      <= 1'b0;
         err_line      <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (take && !take_entry.mask) begin
                  if (mode_reserved(take_entry.mode)) begin
                     err_flag <= 1'b1;
                     err_line <= take_idx;
                  end else if (!take_entry.dm || take_entry.dest != '0) begin
                     msg_dest      <= take_entry.dest;
                     msg_vector    <= take_entry.vec;
                     msg_mode      <= take_entry.mode;
                     msg_dest_mode <= take_entry.dm;
                     msg_valid     <= 1'b1;
                     state_q       <= ST_SEND;
                     if (take_entry.dm) begin
                        msg_target <= DEST_W'(ent_low);
                        remain_q   <= take_entry.dest & ~(DEST_W'(1) << ent_low);
                     end else begin
                        msg_target <= take_entry.dest;
                        remain_q   <= '0;
                     end
                  end
               end
            end
            ST_SEND: begin
               if (msg_ready) begin
                  if (remain_q != '0) begin
                     msg_target <= DEST_W'(rem_low);
                     remain_q   <= remain_q & ~(DEST_W'(1) << rem_low);
                  end else begin
                     msg_valid <= 1'b0;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q == ST_SEND);

   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_target) && $stable(msg_dest)
         && $stable(msg_vector) && $stable(msg_mode) && $stable(msg_dest_mode)));

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   assert_no_reserved_msg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !mode_reserved(msg_mode));

   assert_phys_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_dest_mode) |-> (msg_target == msg_dest));

   assert_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && msg_dest_mode && remain_q != '0)
         |=> (msg_valid && msg_target > $past(msg_target)));

   assert_busy_until_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !msg_ready) |=> busy);
endmodule

// File: rtl/irq_redirect_dispatch.sv
module irq_redirect_dispatch
   import irqd_pkg::*;
#(
   parameter int NUM_LINES = 24,
   localparam int IDX_W = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 cfg_wr_en,
   input  logic [IDX_W-1:0]     cfg_wr_idx,
   input  logic                 cfg_wr_hi,
   input  logic [31:0]          cfg_wr_data,
   output logic                 msg_valid,
   input  logic                 msg_ready,
   output logic [7:0]           msg_target,
   output logic [7:0]           msg_dest,
   output logic [7:0]           msg_vector,
   output logic [2:0]           msg_mode,
   output logic                 msg_dest_mode,
   output logic                 busy,
   output logic                 err_flag,
   output logic [IDX_W-1:0]     err_line
);
   if (NUM_LINES < 2 || NUM_LINES > 256) begin : g_bad_lines
      $error("NUM_LINES must lie in 2..256");
   end
   if (CFG_W != 32 || DEST_W != 8) begin : g_bad_fmt
      $error("register format assumes 32-bit halves and an 8-bit destination");
   end

   logic             sel_valid, take;
   logic [IDX_W-1:0] sel_idx;
   redir_entry_t     sel_entry;

   assign take = sel_valid && !busy;

   irqd_edge_latch #(.NUM_LINES(NUM_LINES)) u_edge (
      .clk(clk), .rst_n(rst_n), .lines(irq_lines), .take(take),
      .sel_valid(sel_valid), .sel_idx(sel_idx)
   );

   irqd_table #(.NUM_LINES(NUM_LINES)) u_table (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx),
      .wr_hi(cfg_wr_hi), .wr_data(cfg_wr_data), .rd_idx(sel_idx),
      .rd_entry(sel_entry)
   );

   irqd_fanout #(.NUM_LINES(NUM_LINES)) u_fanout (
      .clk(clk), .rst_n(rst_n), .take(take), .take_idx(sel_idx),
      .take_entry(sel_entry), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_target(msg_target), .msg_dest(msg_dest), .msg_vector(msg_vector),
      .msg_mode(msg_mode), .msg_dest_mode(msg_dest_mode), .busy(busy),
      .err_flag(err_flag), .err_line(err_line)
   );

   assert_take_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> !$rose(err_flag));
endmodule

// File: tb/tb_irq_redirect_dispatch.sv
module tb_irq_redirect_dispatch;
   localparam int N  = 24;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_lines = '0;
   logic          cfg_wr_en = 1'b0;
   logic [IW-1:0] cfg_wr_idx = '0;
   logic          cfg_wr_hi = 1'b0;
   logic [31:0]   cfg_wr_data = '0;
   logic          msg_valid, msg_ready = 1'b0;
   logic [7:0]    msg_target, msg_dest, msg_vector;
   logic [2:0]    msg_mode;
   logic          msg_dest_mode, busy, err_flag;
   logic [IW-1:0] err_line;

   irq_redirect_dispatch #(.NUM_LINES(N)) dut (.*);

   always #10 clk = ~clk;

   int checks = 0, fails = 0;
   int rdy_mode = 0;
   logic mon_en = 1'b0;
   logic [27:0] got_q[$];
   logic [27:0] exp_q[$];

   logic       m_mask [N];
   logic       m_dm   [N];
   logic [2:0] m_mode [N];
   logic [7:0] m_vec  [N];
   logic [7:0] m_dest [N];
   logic       exp_err = 1'b0;
   int         exp_err_line = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (rdy_mode == 1) msg_ready = $urandom % 2;
      else if (rdy_mode == 2) msg_ready = 1'b1;
      else msg_ready = 1'b0;
   end

   always @(negedge clk)
      if (mon_en && msg_valid && msg_ready)
         got_q.push_back({msg_target, msg_dest, msg_vector, msg_mode, msg_dest_mode});

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
         end
      end
   end

   task automatic prog(input int ln, input logic mk, input logic [2:0] md,
                       input logic dm, input logic [7:0] vec, input logic [7:0] dst);
      @(posedge clk); #2;
      cfg_wr_en = 1; cfg_wr_idx = IW'(ln); cfg_wr_hi = 0;
      cfg_wr_data = ({$urandom} & 32'h00FE_F000) | (32'(mk) << 16) | (32'(dm) << 11)
                    | (32'(md) << 8) | 32'(vec);
      @(posedge clk); #2;
      cfg_wr_hi = 1; cfg_wr_data = ({$urandom} & 32'h00FF_FFFF) | (32'(dst) << 24);
      @(posedge clk); #2;
      cfg_wr_en = 0;
      m_mask[ln] = mk; m_mode[ln] = md; m_dm[ln] = dm; m_vec[ln] = vec; m_dest[ln] = dst;
   endtask

   task automatic model_line(input int ln);
      if (m_mask[ln]) return;
      if (m_mode[ln] == 3 || m_mode[ln] == 6) begin
         exp_err = 1; exp_err_line = ln; return;
      end
      if (!m_dm[ln])
         exp_q.push_back({m_dest[ln], m_dest[ln], m_vec[ln], m_mode[ln], 1'b0});
      else
         for (int b = 0; b < 8; b++)
            if (m_dest[ln][b])
               exp_q.push_back({8'(b), m_dest[ln], m_vec[ln], m_mode[ln], 1'b1});
   endtask

   task automatic pulse(input logic [N-1:0] set);
      @(posedge clk); #2; irq_lines = set;
      @(posedge clk); #2; irq_lines = '0;
      for (int i = 0; i < N; i++) if (set[i]) model_line(i);
   endtask

   task automatic drain();
      int quiet = 0;
      while (quiet < 30) begin
         @(negedge clk);
         if (!busy && !msg_valid) quiet++; else quiet = 0;
      end
   endtask

   task automatic compare(input string req);
      chk({req, " count"}, 64'(got_q.size()), 64'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         chk({req, " msg"}, 64'(got_q[i]), 64'(exp_q[i]));
      chk("R6 err_flag", 64'(err_flag), 64'(exp_err));
      if (exp_err) chk("R6 err_line", 64'(err_line), 64'(exp_err_line));
      got_q.delete(); exp_q.delete();
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < N; i++) begin
         m_mask[i] = 1; m_dm[i] = 0; m_mode[i] = 0; m_vec[i] = 0; m_dest[i] = 0;
      end
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      chk("R1 valid", 64'(msg_valid), 0);
      chk("R1 busy", 64'(busy), 0);
      chk("R1 err", 64'(err_flag), 0);
      mon_en = 1; rdy_mode = 2;

      // R1: every entry masked after reset
      pulse('1); drain(); compare("R1 masked-at-reset");

      // R2, R4: physical, field decode
      prog(4, 0, 3'd0, 0, 8'h41, 8'h9C);
      pulse(N'(1) << 4); drain(); compare("R4 physical");

      // R3: masked entry dropped
      prog(6, 1, 3'd4, 0, 8'h22, 8'h05);
      pulse(N'(1) << 6); drain(); compare("R3 masked");

      // R5: logical fan-out and zero mask
      rdy_mode = 1;
      prog(7, 0, 3'd1, 1, 8'h70, 8'hA5);
      prog(8, 0, 3'd5, 1, 8'h71, 8'h00);
      prog(9, 0, 3'd7, 1, 8'h72, 8'hFF);
      pulse((N'(1) << 7) | (N'(1) << 8) | (N'(1) << 9)); drain(); compare("R5 logical");

      // R6: reserved modes
      prog(10, 0, 3'd3, 0, 8'h10, 8'h01);
      prog(12, 0, 3'd6, 1, 8'h11, 8'h0F);
      pulse(N'(1) << 12); drain(); compare("R6 reserved6");
      pulse(N'(1) << 10); drain(); compare("R6 reserved3");

      // R7: held-high line counts once
      @(posedge clk); #2; irq_lines[4] = 1;
      repeat (10) @(posedge clk);
      #2 irq_lines[4] = 0;
      model_line(4); drain(); compare("R7 held-level");

      // R8, R9: stall during fan-out, later lower line held
      rdy_mode = 0;
      prog(5, 0, 3'd0, 1, 8'h55, 8'h86);
      prog(1, 0, 3'd2, 0, 8'h66, 8'h03);
      pulse(N'(1) << 5);
      pulse(N'(1) << 1);
      repeat (3) @(negedge clk);
      chk("R8 busy during stall", 64'(busy), 1);
      chk("R9 valid held", 64'(msg_valid), 1);
      chk("R9 target held", 64'(msg_target), 1);
      repeat (4) @(negedge clk);
      chk("R9 target still held", 64'(msg_target), 1);
      chk("R9 vector held", 64'(msg_vector), 8'h55);
      rdy_mode = 2;
      drain(); compare("R8 order");

      // random
      rdy_mode = 1;
      for (int it = 0; it < 40; it++) begin
         for (int k = 0; k < 5; k++)
            prog($urandom % N, ($urandom % 5) == 0, 3'($urandom), 1'($urandom),
                 8'($urandom), 8'($urandom));
         pulse(N'($urandom) & N'($urandom));
         drain(); compare("R7 random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule